// File: doc/BRIEF.md
# Reversible-Gate Synchronous Up Counter

This block is a modulo-2^N synchronous up counter whose next-state logic is made only of reversible primitives. The primitives are the controlled-NOT (one control), the three-line Toffoli (two controls), and multi-control Toffoli gates. Each multi-control gate is built as a chain of three-line Toffolis that use zero-initialised helper lines. The present state and the count-enable line enter a cascade of gates. Each gate flips one state bit when the enable and every lower state bit are 1. Bit 0 only needs the enable. A row of controlled-NOT gates with constant-0 targets then copies the next state. The copy is what the state register captures on the rising clock edge.

The helper lines and the enable line leave the cascade as garbage outputs, and these are visible at the ports. The block also reports two constants for the chosen width: the quantum cost and the garbage-line count of its cascade. Both counts include the copy row. The cost model charges 1 for a controlled-NOT and 5 for each three-line Toffoli in a chain. The width N may range from 3 to 8, and any other value is rejected at elaboration.

Top module: `rev_counter`

## Requirements
- R1: A synchronous reset (`rst` = 1 at a rising edge) loads state 0, and it takes priority over `cnt_en`.
- R2: With `rst` = 0 and `cnt_en` = 1, `q_o` increases by exactly one at each rising edge.
- R3: With `rst` = 0 and `cnt_en` = 0, `q_o` keeps its value across a rising edge.
- R4: An enabled edge taken from state 2^N-1 gives state 0.
- R5: `nxt_o` always equals (`q_o` + `cnt_en`) mod 2^N, and each non-reset edge loads `q_o` with the `nxt_o` value seen before that edge.
- R6: Garbage bit 0 (`garb_o[0]`) carries the pass-through of `cnt_en`.
- R7: The gate that targets state bit i (i >= 2) owns i-1 helper lines, starting at garbage bit 1 + (i-2)(i-1)/2. Its helper line j (j = 0 .. i-2) equals `cnt_en` AND `q_o[0]` AND ... AND `q_o[j]`.
- R8: `cost_o` equals N + 1 + 5N(N-1)/2, which gives 19 for N = 3 and 35 for N = 4.
- R9: `garb_cnt_o` equals 1 + (N-1)(N-2)/2 and matches the width of `garb_o`. This gives 2 for N = 3 and 4 for N = 4.
- R10: Every gate variant used is a bijection on all its lines, including the helper lines. Its control lines pass through unchanged. When the helper inputs are 0, its target output equals the target input XOR the AND of all controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, which is a control line of every gate in the cascade |
| q_o | output | N | Present counter state |
| nxt_o | output | N | Next-state lines leaving the copy row |
| garb_o | output | GARB_W | Garbage lines: bit 0 is the enable pass-through, the rest are helper lines |
| cost_o | output | COST_W | Quantum cost of cascade plus copy row |
| garb_cnt_o | output | CNT_W | Number of garbage lines |

## Verification
The assertions assume that `rst` is high from time zero through the first rising edge. They also assume that `cnt_en` is a clean 0 or 1 and only changes away from the rising edge. Only under these conditions do the state-step and garbage relations have defined values to compare. The bench asserts reset before the clock starts and holds `cnt_en` at 0 until reset has run. After that it changes `rst` and `cnt_en` only on falling edges. This keeps every input stable for half a period before each rising edge, including the random-enable stretch that crosses the wrap point many times.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

   localparam int CNOT_COST = 1;
   localparam int TOF_COST  = 5;

   // cost of a gate with k controls built as a Toffoli chain
   function automatic int mct_cost(input int k);
      return (k <= 1) ? CNOT_COST : TOF_COST * (k - 1);
   endfunction

   // helper lines left as garbage by a gate with k controls
   function automatic int mct_garb(input int k);
      return (k > 2) ? k - 2 : 0;
   endfunction

   // first garbage bit owned by the gate targeting state bit i (i >= 2)
   function automatic int garb_off(input int i);
      return 1 + ((i - 2) * (i - 1)) / 2;
   endfunction

   function automatic int counter_cost(input int n);
      int t;
      t = n * CNOT_COST;
      for (int i = 0; i < n; i++) t += mct_cost(i + 1);
      return t;
   endfunction

   function automatic int counter_garb(input int n);
      int t;
      t = 1;
      for (int i = 0; i < n; i++) t += mct_garb(i + 1);
      return t;
   endfunction

endpackage

// File: rtl/rev_cnot.sv
module rev_cnot (
   input  logic ctl_i,
   input  logic tgt_i,
   output logic ctl_o,
   output logic tgt_o
);
   assign ctl_o = ctl_i;
   assign tgt_o = tgt_i ^ ctl_i;
endmodule

// File: rtl/rev_tof.sv
module rev_tof (
   input  logic [1:0] ctl_i,
   input  logic       tgt_i,
   output logic [1:0] ctl_o,
   output logic       tgt_o
);
   assign ctl_o = ctl_i;
   assign tgt_o = tgt_i ^ (ctl_i[0] & ctl_i[1]);
endmodule

// File: rtl/rev_mct.sv
// Multi-control Toffoli as a chain of three-line Toffolis. Helper line g
// accumulates the AND of the first g+2 controls and is not restored.
module rev_mct #(
   parameter int NCTRL = 3,
   localparam int NA = NCTRL - 2
) (
   input  logic [NCTRL-1:0] ctl_i,
   input  logic             tgt_i,
   input  logic [NA-1:0]    anc_i,
   output logic [NCTRL-1:0] ctl_o,
   output logic             tgt_o,
   output logic [NA-1:0]    anc_o
);
   if (NCTRL < 3) begin : g_bad_ctrl
      $error("rev_mct needs at least three controls");
   end

   wire [NA-1:0]    anc_mid;
   wire [NA-1:0]    anc_fw;
   wire [NCTRL-1:0] ctl_fw;

   for (genvar g = 0; g < NCTRL - 1; g++) begin : g_stage
      logic [1:0] ci;
      logic [1:0] co;
      logic       ti;
      logic       to;

      if (g == 0) begin : g_first
         assign ci = {ctl_i[1], ctl_i[0]};
      end else begin : g_next
         assign ci = {ctl_i[g+1], anc_mid[g-1]};
      end

      if (g == NCTRL - 2) begin : g_last_tgt
         assign ti    = tgt_i;
         assign tgt_o = to;
      end else begin : g_anc_tgt
         assign ti         = anc_i[g];
         assign anc_mid[g] = to;
      end

      rev_tof u_tof (
         .ctl_i(ci),
         .tgt_i(ti),
         .ctl_o(co),
         .tgt_o(to)
      );

      if (g == 0) begin : g_fw_first
         assign ctl_fw[1:0] = co;
      end else begin : g_fw_next
         assign ctl_fw[g+1]  = co[1];
         assign anc_fw[g-1]  = co[0];
      end
   end

   assign ctl_o = ctl_fw;
   assign anc_o = anc_fw;
endmodule

// File: rtl/rev_counter.sv
module rev_counter #(
   parameter int N      = 4,
   parameter int COST_W = 16,
   parameter int CNT_W  = 8,
   localparam int GARB_W = rgc_pkg::counter_garb(N)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cnt_en,
   output logic [N-1:0]      q_o,
   output logic [N-1:0]      nxt_o,
   output logic [GARB_W-1:0] garb_o,
   output logic [COST_W-1:0] cost_o,
   output logic [CNT_W-1:0]  garb_cnt_o
);
   localparam int COST = rgc_pkg::counter_cost(N);

   if (N < 3 || N > 8) begin : g_bad_n
      $error("rev_counter width must lie in 3..8");
   end
   if (COST >= (1 << COST_W) || GARB_W >= (1 << CNT_W)) begin : g_bad_w
      $error("rev_counter report fields too narrow");
   end

   logic [N-1:0] state_q;
   logic [N-1:0] cpy;
   logic [N-1:0] st [0:N];
   logic         cl [0:N];

   assign st[0] = state_q;
   assign cl[0] = cnt_en;

   // stage s targets bit N-1-s: upper bits flip first, on the present state
   for (genvar s = 0; s < N; s++) begin : g_casc
      localparam int I = N - 1 - s;
      localparam logic [N-1:0] HI = ~((N'(2) << I) - N'(1));
      logic [N-1:0] low_o;
      logic         tgt_q;
      logic         c_o;

      if (I == 0) begin : g_cnot
         rev_cnot u_g (
            .ctl_i(cl[s]),
            .tgt_i(st[s][0]),
            .ctl_o(c_o),
            .tgt_o(tgt_q)
         );
         assign low_o = '0;
      end else if (I == 1) begin : g_tof
         logic [1:0] co;
         rev_tof u_g (
            .ctl_i({st[s][0], cl[s]}),
            .tgt_i(st[s][1]),
            .ctl_o(co),
            .tgt_o(tgt_q)
         );
         assign c_o   = co[0];
         assign low_o = N'(co[1]);
      end else begin : g_mct
         localparam int OFF = rgc_pkg::garb_off(I);
         logic [I:0] co;
         rev_mct #(.NCTRL(I + 1)) u_g (
            .ctl_i({st[s][I-1:0], cl[s]}),
            .tgt_i(st[s][I]),
            .anc_i('0),
            .ctl_o(co),
            .tgt_o(tgt_q),
            .anc_o(garb_o[OFF +: I-1])
         );
         assign c_o   = co[0];
         assign low_o = N'(co[I:1]);
      end

      assign st[s+1] = (st[s] & HI) | (N'(tgt_q) << I) | low_o;
      assign cl[s+1] = c_o;
   end

   assign garb_o[0] = cl[N];

   // copy row: constant-0 targets receive the next state for feedback
   for (genvar b = 0; b < N; b++) begin : g_copy
      rev_cnot u_cp (
         .ctl_i(st[N][b]),
         .tgt_i(1'b0),
         .ctl_o(nxt_o[b]),
         .tgt_o(cpy[b])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= '0;
      else     state_q <= cpy;
   end

   assign q_o        = state_q;
   assign cost_o     = COST_W'(COST);
   assign garb_cnt_o = CNT_W'(GARB_W);
endmodule

// File: rtl/rev_counter_chk.sv
module rev_counter_chk #(
   parameter int N      = 4,
   parameter int GARB_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cnt_en,
   input logic [N-1:0]      q_o,
   input logic [N-1:0]      nxt_o,
   input logic [GARB_W-1:0] garb_o
);
   p_reset_r1: assert property (@(posedge clk) rst |=> q_o == '0);

   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_en |=> q_o == N'($past(q_o) + 1'b1));

   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(q_o));

   p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && q_o == '1) |=> q_o == '0);

   p_load_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> q_o == $past(nxt_o));

   p_cline_r6: assert property (@(posedge clk) disable iff (rst)
      garb_o[0] == cnt_en);

   p_anc_first_r7: assert property (@(posedge clk) disable iff (rst)
      garb_o[1] == (cnt_en & q_o[0]));

   p_anc_last_r7: assert property (@(posedge clk) disable iff (rst)
      garb_o[GARB_W-1] == (cnt_en & (&q_o[N-3:0])));
endmodule

bind rev_counter rev_counter_chk #(.N(N), .GARB_W(GARB_W)) u_chk (
   .clk(clk),
   .rst(rst),
   .cnt_en(cnt_en),
   .q_o(q_o),
   .nxt_o(nxt_o),
   .garb_o(garb_o)
);

// File: tb/rev_counter_test.sv
module rev_counter_test;
   localparam int N      = 4;
   localparam int COST_W = 16;
   localparam int CNT_W  = 8;
   localparam int GW     = 1 + ((N - 1) * (N - 2)) / 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cnt_en = 1'b0;
   logic [N-1:0]  q_o, nxt_o;
   logic [GW-1:0] garb_o;
   logic [COST_W-1:0] cost_o;
   logic [CNT_W-1:0]  garb_cnt_o;

   int checks = 0;
   int fails  = 0;
   int bij_count = 0;
   bit live = 0;
   logic [N-1:0] model = '0;
   logic [N-1:0] exp_q [$];
   string        tag_q [$];

   always #4 clk = ~clk;

   rev_counter #(.N(N), .COST_W(COST_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .q_o(q_o), .nxt_o(nxt_o),
      .garb_o(garb_o), .cost_o(cost_o), .garb_cnt_o(garb_cnt_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   function automatic logic [GW-1:0] exp_garb(input logic [N-1:0] q, input logic c);
      logic [GW-1:0] g;
      logic          p;
      g    = '0;
      g[0] = c;
      for (int i = 2; i < N; i++) begin
         p = c;
         for (int j = 0; j <= i - 2; j++) begin
            p = p & q[j];
            g[1 + ((i - 2) * (i - 1)) / 2 + j] = p;
         end
      end
      return g;
   endfunction

   // driver: sets inputs on the falling edge, checks combinational lines,
   // pushes the state expected after the next rising edge
   task automatic drive(input logic r, input logic c, input string tag);
      @(negedge clk);
      rst = r;
      cnt_en = c;
      #1;
      if (!r && live) begin
         chk(nxt_o === N'(model + c), "R5 nxt_o", nxt_o, N'(model + c));
         chk(garb_o[0] === c, "R6 enable line", garb_o[0], c);
         chk(garb_o === exp_garb(model, c), "R7 helper lines", garb_o, exp_garb(model, c));
      end
      if (r) begin
         model = '0;
         live  = 1;
      end else begin
         model = N'(model + c);
      end
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   // monitor: pops after each rising edge
   always begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
         logic [N-1:0] e;
         string        t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(q_o === e, t, q_o, e);
      end
   end

   // exhaustive bijection of every gate variant the counter uses (R10)
   for (genvar k = 1; k <= N; k++) begin : g_bij
      localparam int NA = (k > 2) ? k - 2 : 0;
      localparam int L  = k + 1 + NA;
      logic [L-1:0] vin;
      wire  [L-1:0] vout;

      if (k == 1) begin : g_c
         rev_cnot u (.ctl_i(vin[0]), .tgt_i(vin[1]), .ctl_o(vout[0]), .tgt_o(vout[1]));
      end else if (k == 2) begin : g_t
         rev_tof u (.ctl_i(vin[1:0]), .tgt_i(vin[2]), .ctl_o(vout[1:0]), .tgt_o(vout[2]));
      end else begin : g_m
         rev_mct #(.NCTRL(k)) u (
            .ctl_i(vin[k-1:0]), .tgt_i(vin[k]), .anc_i(vin[L-1:k+1]),
            .ctl_o(vout[k-1:0]), .tgt_o(vout[k]), .anc_o(vout[L-1:k+1])
         );
      end

      initial begin
         bit seen [];
         int dup;
         int bad;
         seen = new[1 << L];
         dup  = 0;
         bad  = 0;
         for (int v = 0; v < (1 << L); v++) begin
            vin = L'(v);
            #1;
            if (seen[vout]) dup++;
            seen[vout] = 1'b1;
            if (vout[k-1:0] !== vin[k-1:0]) bad++;
            if ((vin >> (k + 1)) == 0 && vout[k] !== (vin[k] ^ (&vin[k-1:0]))) bad++;
         end
         chk(dup == 0, $sformatf("R10 bijection k=%0d", k), dup, 0);
         chk(bad == 0, $sformatf("R10 gate function k=%0d", k), bad, 0);
         bij_count++;
      end
   end

   initial begin
      #1;
      chk(cost_o == COST_W'(N + 1 + 5 * N * (N - 1) / 2), "R8 cost", cost_o, N + 1 + 5 * N * (N - 1) / 2);
      chk(cost_o == 35, "R8 cost N=4", cost_o, 35);
      chk(garb_cnt_o == CNT_W'(GW) && $bits(garb_o) == GW, "R9 garbage count", garb_cnt_o, GW);
      chk(garb_cnt_o == 4, "R9 garbage count N=4", garb_cnt_o, 4);

      drive(1'b1, 1'b0, "R1 reset");
      drive(1'b1, 1'b1, "R1 reset over enable");
      repeat (20) drive(1'b0, 1'b1, "R2 count");
      repeat (5) drive(1'b0, 1'b0, "R3 hold");
      while (model != '1) drive(1'b0, 1'b1, "R2 count to top");
      drive(1'b0, 1'b0, "R3 hold at top");
      drive(1'b0, 1'b1, "R4 wrap");
      repeat (400) drive(1'b0, 1'($urandom_range(0, 1)), "R5 random enable");
      while (model != '1) drive(1'b0, 1'b1, "R2 count to top");
      drive(1'b1, 1'b1, "R1 reset at top");
      repeat (3) drive(1'b0, 1'b1, "R2 count after reset");
      drive(1'b0, 1'b0, "R3 hold");
      @(posedge clk);
      #3;
      wait (bij_count == N);
      summary();
      $finish;
   end

   initial begin
      #(8 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end
endmodule